// File: doc/BRIEF.md
# Tape Motion Command and Tester Logic

This block turns the drive's ready status, held movement commands from the host and the local test buttons into the two capstan direction requests and a brake output. The drive goes online when the operator presses Start while the tape loops already sit inside the vacuum column limits. Once online, the drive first runs in reverse until the load point is seen. After that it passes each host command straight through for as long as the host holds it.

While the drive is offline, a local pushbutton puts the block into tester mode. In tester mode, two direction buttons move the tape while they are pressed. Alternatively, an automatic mode alternates forward and reverse in equal timed phases. The direction outputs never overlap, and the brake is applied whenever neither direction is requested.

Top module: `tape_motion_ctl`

## Requirements
- R1: The `ready` output rises at the first clock edge that samples `start_btn`=1 and `in_limit`=1 while the drive is offline. Pressing `start_btn` while `in_limit`=0 leaves `ready` at 0.
- R2: From the edge that sets `ready`, `rev_req` is 1 until an edge samples `bot`=1 together with `eot`=0. After that edge `rev_req` is 0 and `brake` is 1. When `bot`=1 and `eot`=1, the seek does not stop.
- R3: Once the seek has ended, host commands act combinationally for as long as they are held, with priority unload > rewind > reverse > forward. Unload and rewind request reverse motion. `unload_out` follows unload, and `rewind_out` follows rewind when unload is not asserted.
- R4: While `bot`=1, reverse requests from host reverse, host rewind and the tester are suppressed. Host unload is not suppressed.
- R5: `test_mode_btn` sets `tester_on` at the next edge only while the drive is offline. While the drive is online, the button is ignored. `tester_on` and `ready` are never both 1.
- R6: In tester mode with `test_auto`=0, `fwd_req` follows `test_fwd_btn` when it is pressed alone, and `rev_req` follows `test_rev_btn` when it is pressed alone. With both buttons pressed, neither direction is requested.
- R7: In tester mode with `test_auto`=1, the block requests forward for PHASE_CYCLES clock edges and then reverse for PHASE_CYCLES edges, repeating. It starts in the forward phase. Dropping `test_auto` returns the cycle to its start.
- R8: While `rewind_held`=1, the tester never requests forward, in either the button mode or the automatic mode.
- R9: `fwd_req` and `rev_req` are never both 1. `brake` is 1 exactly when neither of them is 1.
- R10: `reset_btn` clears `ready`, the seek and `tester_on` at the next edge. The motion outputs are then idle.
- R11: After `rst_n` is asserted, and whenever the drive is offline outside tester mode, all motion requests are 0 and `brake` is 1. Host commands have no effect in this condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_btn | input | 1 | Operator reset; takes the drive offline |
| start_btn | input | 1 | Operator Start button |
| in_limit | input | 1 | Tape loops are between the column limit sensors |
| bot | input | 1 | Load point marker is seen |
| eot | input | 1 | End marker is seen |
| host_fwd | input | 1 | Host forward command (held) |
| host_rev | input | 1 | Host reverse command (held) |
| host_rew | input | 1 | Host rewind command (held) |
| host_unload | input | 1 | Host unload command (held) |
| test_mode_btn | input | 1 | Local button that enters tester mode |
| test_fwd_btn | input | 1 | Tester forward button |
| test_rev_btn | input | 1 | Tester reverse button |
| test_auto | input | 1 | Selects automatic alternating tester motion |
| rewind_held | input | 1 | Rewind latch state; blocks tester forward |
| ready | output | 1 | Drive is online and ready |
| tester_on | output | 1 | Tester mode is active |
| fwd_req | output | 1 | Capstan forward request |
| rev_req | output | 1 | Capstan reverse request |
| brake | output | 1 | Brake applied |
| rewind_out | output | 1 | Rewind in progress toward the motion drives |
| unload_out | output | 1 | Unload in progress toward the motion drives |

## Verification
The state flags `ready`, the seek flag and `tester_on` change one clock edge after the input that causes them. The bench therefore drives inputs just after a falling edge and checks these flags at the next falling edge. The host and tester direction paths are combinational from the held inputs. They are checked one nanosecond after the drive, with no clock edge in between. The automatic tester phase flips after exactly PHASE_CYCLES rising edges, so the bench counts edges from the falling edge at which `test_auto` is raised. It samples just before and just after each phase boundary.

// File: rtl/tape_motion_pkg.sv
package tape_motion_pkg;

  typedef struct packed {
    logic fwd;
    logic rev;
  } motion_t;

  // Host command resolution: unload > rewind > reverse > forward.
  function automatic motion_t host_pick(logic f, logic r, logic rw, logic un, logic at_bot);
    motion_t m;
    m = '0;
    if (un)            m.rev = 1'b1;
    else if (rw || r)  m.rev = !at_bot;
    else if (f)        m.fwd = 1'b1;
    return m;
  endfunction

  // Tester request from buttons or from the alternating phase.
  function automatic motion_t tester_pick(logic fb, logic rb, logic auto_sel, logic phase,
                                          logic rew_held, logic at_bot);
    motion_t m;
    m = '0;
    if (auto_sel) begin
      m.fwd = !phase && !rew_held;
      m.rev = phase && !at_bot;
    end else begin
      m.fwd = fb && !rb && !rew_held;
      m.rev = rb && !fb && !at_bot;
    end
    return m;
  endfunction

  // Phase counter step: wraps at last and reports the wrap.
  function automatic logic phase_wrap(int unsigned cnt, int unsigned last);
    return cnt == last;
  endfunction

endpackage

// File: rtl/tm_ready_ctl.sv
module tm_ready_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_btn,
  input  logic start_btn,
  input  logic in_limit,
  input  logic bot,
  input  logic eot,
  output logic online,
  output logic seeking,
  output logic go_online
);

  logic seek_done;

  assign go_online = !online && start_btn && in_limit && !reset_btn;
  assign seek_done = bot && !eot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      online  <= 1'b0;
      seeking <= 1'b0;
    end else if (reset_btn) begin
      online  <= 1'b0;
      seeking <= 1'b0;
    end else if (go_online) begin
      online  <= 1'b1;
      seeking <= 1'b1;
    end else if (seeking && seek_done) begin
      seeking <= 1'b0;
    end
  end

  AST_READY_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (online && !$past(online)) |-> $past(start_btn && in_limit)); // R1
  AST_SEEK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (seeking && bot && !eot) |=> !seeking); // R2
  AST_SEEK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (seeking && !(bot && !eot) && !reset_btn) |=> seeking); // R2
  AST_RESET_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_btn |=> (!online && !seeking)); // R10

endmodule

// File: rtl/tm_tester.sv
module tm_tester
  import tape_motion_pkg::*;
#(
  parameter int unsigned PHASE_CYCLES = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reset_btn,
  input  logic    online,
  input  logic    go_online,
  input  logic    test_mode_btn,
  input  logic    test_fwd_btn,
  input  logic    test_rev_btn,
  input  logic    test_auto,
  input  logic    rewind_held,
  input  logic    bot,
  output logic    tester_on,
  output motion_t test_motion
);

  localparam int unsigned CNT_W = (PHASE_CYCLES > 2) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             phase;
  logic             auto_run;
  logic             wrap;

  assign auto_run = tester_on && test_auto;
  assign wrap     = phase_wrap(int'(cnt), int'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  tester_on <= 1'b0;
    else if (reset_btn || online || go_online)   tester_on <= 1'b0;
    else if (test_mode_btn)                      tester_on <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!auto_run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= !phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  always_comb begin
    if (tester_on)
      test_motion = tester_pick(test_fwd_btn, test_rev_btn, test_auto, phase, rewind_held, bot);
    else
      test_motion = '0;
  end

  AST_TESTER_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
    tester_on |-> !online); // R5
  AST_AUTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_run |=> (cnt == '0 && !phase)); // R7
  AST_PHASE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_run && !wrap) |=> $stable(phase)); // R7
  AST_REW_BLOCKS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_held |-> !test_motion.fwd); // R8

endmodule

// File: rtl/tm_arbiter.sv
module tm_arbiter
  import tape_motion_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    online,
  input  logic    seeking,
  input  logic    tester_on,
  input  logic    bot,
  input  logic    host_fwd,
  input  logic    host_rev,
  input  logic    host_rew,
  input  logic    host_unload,
  input  motion_t test_motion,
  output logic    fwd_req,
  output logic    rev_req,
  output logic    brake,
  output logic    rewind_out,
  output logic    unload_out
);

  logic    host_live;
  motion_t sel;

  assign host_live = online && !seeking;

  always_comb begin
    sel = '0;
    if (online && seeking)  sel.rev = 1'b1;
    else if (host_live)     sel = host_pick(host_fwd, host_rev, host_rew, host_unload, bot);
    else if (tester_on)     sel = test_motion;
  end

  assign fwd_req    = sel.fwd && !sel.rev;
  assign rev_req    = sel.rev;
  assign brake      = !(fwd_req || rev_req);
  assign unload_out = host_live && host_unload;
  assign rewind_out = host_live && host_rew && !host_unload;

  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_req && rev_req)); // R9
  AST_IDLE_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (!online && !tester_on) |-> (brake && !rewind_out && !unload_out)); // R11
  AST_BOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bot && rev_req) |-> (seeking || unload_out)); // R4

endmodule

// File: rtl/tape_motion_ctl.sv
module tape_motion_ctl
  import tape_motion_pkg::*;
#(
  parameter int unsigned PHASE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_btn,
  input  logic start_btn,
  input  logic in_limit,
  input  logic bot,
  input  logic eot,
  input  logic host_fwd,
  input  logic host_rev,
  input  logic host_rew,
  input  logic host_unload,
  input  logic test_mode_btn,
  input  logic test_fwd_btn,
  input  logic test_rev_btn,
  input  logic test_auto,
  input  logic rewind_held,
  output logic ready,
  output logic tester_on,
  output logic fwd_req,
  output logic rev_req,
  output logic brake,
  output logic rewind_out,
  output logic unload_out
);

  logic    online;
  logic    seeking;
  logic    go_online;
  motion_t test_motion;

  tm_ready_ctl u_ready (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_btn (reset_btn),
    .start_btn (start_btn),
    .in_limit  (in_limit),
    .bot       (bot),
    .eot       (eot),
    .online    (online),
    .seeking   (seeking),
    .go_online (go_online)
  );

  tm_tester #(.PHASE_CYCLES(PHASE_CYCLES)) u_tester (
    .clk           (clk),
    .rst_n         (rst_n),
    .reset_btn     (reset_btn),
    .online        (online),
    .go_online     (go_online),
    .test_mode_btn (test_mode_btn),
    .test_fwd_btn  (test_fwd_btn),
    .test_rev_btn  (test_rev_btn),
    .test_auto     (test_auto),
    .rewind_held   (rewind_held),
    .bot           (bot),
    .tester_on     (tester_on),
    .test_motion   (test_motion)
  );

  tm_arbiter u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .online      (online),
    .seeking     (seeking),
    .tester_on   (tester_on),
    .bot         (bot),
    .host_fwd    (host_fwd),
    .host_rev    (host_rev),
    .host_rew    (host_rew),
    .host_unload (host_unload),
    .test_motion (test_motion),
    .fwd_req     (fwd_req),
    .rev_req     (rev_req),
    .brake       (brake),
    .rewind_out  (rewind_out),
    .unload_out  (unload_out)
  );

  assign ready = online;

  AST_START_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && start_btn && in_limit && !reset_btn) |=> ready); // R1
  AST_READY_SEEKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && start_btn && in_limit && !reset_btn) |=> rev_req); // R2
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_btn |=> (!ready && !tester_on)); // R10

endmodule

// File: tb/tape_motion_ctl_bench.sv
module tape_motion_ctl_bench;
  localparam int P = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_btn = 0, start_btn = 0, in_limit = 0, bot = 0, eot = 0;
  logic host_fwd = 0, host_rev = 0, host_rew = 0, host_unload = 0;
  logic test_mode_btn = 0, test_fwd_btn = 0, test_rev_btn = 0, test_auto = 0, rewind_held = 0;
  logic ready, tester_on, fwd_req, rev_req, brake, rewind_out, unload_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tape_motion_ctl #(.PHASE_CYCLES(P)) u_tape_motion_ctl (
    .clk(clk), .rst_n(rst_n), .reset_btn(reset_btn), .start_btn(start_btn),
    .in_limit(in_limit), .bot(bot), .eot(eot), .host_fwd(host_fwd),
    .host_rev(host_rev), .host_rew(host_rew), .host_unload(host_unload),
    .test_mode_btn(test_mode_btn), .test_fwd_btn(test_fwd_btn),
    .test_rev_btn(test_rev_btn), .test_auto(test_auto), .rewind_held(rewind_held),
    .ready(ready), .tester_on(tester_on), .fwd_req(fwd_req), .rev_req(rev_req),
    .brake(brake), .rewind_out(rewind_out), .unload_out(unload_out)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Direction outputs checked together with the brake relation (R9).
  task automatic chk_dir(input string req, input logic f, input logic r);
    chk(req, "fwd_req", fwd_req, f);
    chk(req, "rev_req", rev_req, r);
    chk("R9", "brake", brake, !(f || r));
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    chk("R11", "ready after rst", ready, 0);
    chk("R11", "tester after rst", tester_on, 0);
    host_fwd = 1; #1;
    chk_dir("R11", 0, 0);
    host_fwd = 0;
  endtask

  task automatic t_ready_seek;
    start_btn = 1; in_limit = 0; step(1);
    chk("R1", "ready without limit", ready, 0);
    in_limit = 1; step(1);
    start_btn = 0;
    chk("R1", "ready set", ready, 1);
    chk_dir("R2", 0, 1);
    bot = 1; eot = 1; step(2);
    chk_dir("R2", 0, 1);
    eot = 0; step(1);
    chk_dir("R2", 0, 0);
    test_mode_btn = 1; step(1);
    test_mode_btn = 0;
    chk("R5", "tester while online", tester_on, 0);
  endtask

  task automatic t_host;
    host_fwd = 1; #1;
    chk_dir("R3", 1, 0);
    host_rev = 1; #1;
    chk_dir("R4", 0, 0);
    bot = 0; #1;
    chk_dir("R3", 0, 1);
    host_rev = 0; host_rew = 1; #1;
    chk_dir("R3", 0, 1);
    chk("R3", "rewind_out", rewind_out, 1);
    bot = 1; #1;
    chk_dir("R4", 0, 0);
    host_unload = 1; #1;
    chk_dir("R4", 0, 1);
    chk("R3", "unload_out", unload_out, 1);
    chk("R3", "rewind_out under unload", rewind_out, 0);
    host_unload = 0; host_rew = 0; #1;
    chk_dir("R3", 1, 0);
  endtask

  task automatic t_reset_btn;
    step(1);
    reset_btn = 1; step(1);
    reset_btn = 0;
    chk("R10", "ready cleared", ready, 0);
    chk_dir("R10", 0, 0);
    chk("R11", "rewind_out offline", rewind_out, 0);
    host_fwd = 0; bot = 0; in_limit = 0;
  endtask

  task automatic t_tester_manual;
    test_mode_btn = 1; step(1);
    test_mode_btn = 0;
    chk("R5", "tester entered", tester_on, 1);
    test_fwd_btn = 1; #1;
    chk_dir("R6", 1, 0);
    test_rev_btn = 1; #1;
    chk_dir("R6", 0, 0);
    test_fwd_btn = 0; #1;
    chk_dir("R6", 0, 1);
    bot = 1; #1;
    chk_dir("R4", 0, 0);
    bot = 0; test_rev_btn = 0; test_fwd_btn = 1; rewind_held = 1; #1;
    chk_dir("R8", 0, 0);
    rewind_held = 0; test_fwd_btn = 0;
  endtask

  task automatic t_tester_auto;
    step(1);
    test_auto = 1; #1;
    chk_dir("R7", 1, 0);
    step(P - 1);
    chk_dir("R7", 1, 0);
    step(1);
    chk_dir("R7", 0, 1);
    step(P - 1);
    chk_dir("R7", 0, 1);
    step(1);
    chk_dir("R7", 1, 0);
    rewind_held = 1; #1;
    chk_dir("R8", 0, 0);
    rewind_held = 0;
    step(P);
    test_auto = 0; step(1);
    test_auto = 1; #1;
    chk_dir("R7", 1, 0);
    test_auto = 0;
  endtask

  task automatic t_leave_tester;
    step(1);
    start_btn = 1; in_limit = 1; step(1);
    start_btn = 0;
    chk("R5", "tester cleared on ready", tester_on, 0);
    chk("R1", "ready from tester", ready, 1);
    bot = 1; step(1);
    reset_btn = 1; step(1);
    reset_btn = 0;
    chk("R10", "ready cleared again", ready, 0);
    test_mode_btn = 1; step(1);
    test_mode_btn = 0;
    reset_btn = 1; step(1);
    reset_btn = 0;
    chk("R10", "tester cleared by reset", tester_on, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset_state();
    t_ready_seek();
    t_host();
    t_reset_btn();
    t_tester_manual();
    t_tester_auto();
    t_leave_tester();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule